// File: doc/BRIEF.md
# GPIO Rising-Edge Interrupt Aggregator

This block samples 54 general-purpose input pins, turns each qualified low-to-high transition into a sticky pending bit, and folds those pending bits into interrupt lines. The pins are held in two 32-bit banks. Pins 0 to 31 occupy bank 0. Pins 32 to 53 occupy the low 22 bits of bank 1.

Each bank has a rising-edge enable word and a pending-event word. Software reaches both through a single-cycle word port. Pending bits are cleared by writing ones to them.

Three group interrupt lines cover fixed pin ranges that do not follow the bank split. The middle group takes the top four bits of bank 0 together with the low fourteen bits of bank 1. A fourth line is raised whenever any group line is high.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset every pending bit, every enable bit and every interrupt output is 0.
- R2: A 0-to-1 transition on an enabled pin sets that pin's pending bit. The bit is readable on the third rising clock edge after the pin goes high, which covers two synchroniser flops and the edge-capture register.
- R3: An edge on a pin whose enable bit is 0 is not latched. A falling edge is never latched.
- R4: In a write to a pending word, each 1 clears the matching bit and each 0 leaves it as it was. The clear takes effect at the clock edge that samples the write.
- R5: If a new edge and a write-1-to-clear reach the same pending bit in the same cycle, the bit stays set.
- R6: Group line `irq_grp[0]` is high exactly when any pending bit for pins 0–27 is set (bank 0 bits 0–27).
- R7: Group line `irq_grp[1]` is high exactly when any pending bit for pins 28–45 is set (bank 0 bits 28–31 and bank 1 bits 0–13).
- R8: Group line `irq_grp[2]` is high exactly when any pending bit for pins 46–53 is set (bank 1 bits 14–21).
- R9: `irq_any` is the OR of the three group lines. It is high exactly when any pending bit is set.
- R10: Bits 22–31 of the bank 1 pending word and of the bank 1 enable word always read 0, even after writes of all ones.
- R11: The register map uses byte addresses. Pending bank 0 is at 0x0 and pending bank 1 is at 0x4. Enable bank 0 is at 0x8 and enable bank 1 is at 0xC. Reads return data in the same cycle. A read or write to an address whose low two bits are not 00 returns 0 and changes nothing.
- R12: The interrupt outputs follow the pending bits combinationally. They rise in the same cycle as the pending bit and fall in the cycle after the clearing write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gpio_in | input | 54 | Asynchronous pin inputs |
| bus_addr | input | 4 | Byte address of the register access |
| bus_wen | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| irq_grp | output | 3 | Group interrupt lines for pins 0–27, 28–45 and 46–53 |
| irq_any | output | 1 | OR of the group lines |

## Verification
A pin raised at a falling clock edge produces its pending bit and its interrupt lines three rising edges later. The bench therefore waits three rising edges and then samples at the next falling edge.

Writes are driven at a falling edge and take effect at the following rising edge. Their results, including a dropped interrupt line, are checked at the falling edge after that.

For the collision case, the clear is placed in the one cycle where the second synchroniser flop has just turned high, so the edge and the clear meet at the same rising edge. Every check is pushed into the scoreboard queue at the falling edge where its result is due. The monitor compares it 1 ns later, after the combinational read path has settled.

// File: rtl/gpio_irq_pkg.sv
// Shared constants and mask helpers for the GPIO edge interrupt block.
// Assumes every bank is BANK_W bits wide and pins are numbered bank-major.
package gpio_irq_pkg;

    localparam int BANK_W = 32;

    // Bits of a bank whose global pin number lies in [lo, hi].
    function automatic logic [BANK_W-1:0] span_mask(int bank, int lo, int hi);
        logic [BANK_W-1:0] m;
        m = '0;
        for (int i = 0; i < BANK_W; i++) begin
            int p;
            p = bank * BANK_W + i;
            m[i] = (p >= lo) && (p <= hi);
        end
        return m;
    endfunction

    // Bits of a bank that map to an existing pin.
    function automatic logic [BANK_W-1:0] valid_mask(int bank, int npins);
        return span_mask(bank, 0, npins - 1);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; no multi-bit coherency is implied.
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);

    logic [W-1:0] meta_q;

    // Capture the raw inputs, then re-register them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            d_sync <= '0;
        end else begin
            meta_q <= d_async;
            d_sync <= meta_q;
        end
    end

endmodule

// File: rtl/gpio_edge_bank.sv
// One bank: a rising-edge enable word, edge detection and a sticky pending word.
// Assumes pin_s is already synchronised. VALID marks the bits that have a pin;
// the other bits are held at zero. A new edge beats a same-cycle clear.
module gpio_edge_bank #(
    parameter int           W     = 32,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_s,
    input  logic         en_wr,
    input  logic         sts_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_q,
    output logic [W-1:0] sts_q
);

    logic [W-1:0] prev_q;
    logic [W-1:0] rise;
    logic [W-1:0] clr;

    // Qualified rising edges and the write-1-to-clear mask.
    always_comb begin
        rise = pin_s & ~prev_q & en_q & VALID;
        clr  = sts_wr ? wdata : '0;
    end

    // Track the previous synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_s;
    end

    // Enable word, written directly.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= wdata & VALID;
    end

    // Pending word: clear by ones, then set by new edges.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= ((sts_q & ~clr) | rise) & VALID;
    end

endmodule

// File: rtl/gpio_group_or.sv
// OR-reduces the pending bits whose pin numbers lie in [LO, HI] across all banks.
// Assumes the pin numbering of gpio_irq_pkg::span_mask.
module gpio_group_or
    import gpio_irq_pkg::*;
#(
    parameter int NB = 2,
    parameter int LO = 0,
    parameter int HI = 27
) (
    input  logic [NB-1:0][BANK_W-1:0] sts,
    output logic                      irq
);

    logic [NB-1:0] hit;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        localparam logic [BANK_W-1:0] MASK = span_mask(b, LO, HI);
        assign hit[b] = |(sts[b] & MASK);
    end

    assign irq = |hit;

endmodule

// File: rtl/gpio_edge_irq.sv
// GPIO rising-edge interrupt aggregator: synchronises the pins, latches qualified
// edges per bank and drives three range-based group lines plus a combined line.
// Assumes a single-cycle register port with byte addresses that must be word aligned.
module gpio_edge_irq
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS  = 54,
    parameter int G1_FIRST  = 28,
    parameter int G2_FIRST  = 46,
    parameter int ADDR_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] gpio_in,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wen,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [2:0]          irq_grp,
    output logic                irq_any
);

    localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
    localparam int TOT_W     = NUM_BANKS * BANK_W;
    localparam int WORD_W    = ADDR_W - 2;

    logic [NUM_PINS-1:0]               pin_s;
    logic [TOT_W-1:0]                  pin_wide;
    logic [NUM_BANKS-1:0][BANK_W-1:0]  sts_all;
    logic [NUM_BANKS-1:0][BANK_W-1:0]  en_all;
    logic [WORD_W-1:0]                 word;
    logic                              aligned;

    assign word     = bus_addr[ADDR_W-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign pin_wide = TOT_W'(pin_s);

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (gpio_in),
        .d_sync  (pin_s)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sts_wr;
        logic en_wr;
        assign sts_wr = bus_wen && aligned && (word == WORD_W'(b));
        assign en_wr  = bus_wen && aligned && (word == WORD_W'(NUM_BANKS + b));

        gpio_edge_bank #(
            .W     (BANK_W),
            .VALID (valid_mask(b, NUM_PINS))
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_s  (pin_wide[b*BANK_W +: BANK_W]),
            .en_wr  (en_wr),
            .sts_wr (sts_wr),
            .wdata  (bus_wdata),
            .en_q   (en_all[b]),
            .sts_q  (sts_all[b])
        );
    end

    for (genvar g = 0; g < 3; g++) begin : g_grp
        localparam int LO = (g == 0) ? 0 : (g == 1) ? G1_FIRST : G2_FIRST;
        localparam int HI = (g == 0) ? G1_FIRST - 1 : (g == 1) ? G2_FIRST - 1 : NUM_PINS - 1;
        gpio_group_or #(.NB(NUM_BANKS), .LO(LO), .HI(HI)) u_or (
            .sts (sts_all),
            .irq (irq_grp[g])
        );
    end

    assign irq_any = |irq_grp;

    // Same-cycle read mux over pending and enable words.
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (word == WORD_W'(b))             bus_rdata = sts_all[b];
                if (word == WORD_W'(NUM_BANKS + b)) bus_rdata = en_all[b];
            end
        end
    end

endmodule

// File: rtl/gpio_edge_irq_chk.sv
// Checker for gpio_edge_irq: relates the pending and enable words to the
// register port and to the interrupt outputs over time.
module gpio_edge_irq_chk #(
    parameter int NB     = 2,
    parameter int ADDR_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_wen,
    input logic [31:0]            bus_wdata,
    input logic [NB-1:0][31:0]    sts_all,
    input logic [NB-1:0][31:0]    en_all,
    input logic [2:0]             irq_grp,
    input logic                   irq_any
);

    for (genvar b = 0; b < NB; b++) begin : g_chk
        logic [31:0] clr;
        assign clr = (bus_wen && bus_addr == ADDR_W'(4 * b)) ? bus_wdata : '0;

        // R3
        disabled_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((sts_all[b] & ~$past(sts_all[b]) & ~$past(en_all[b])) == '0));

        // R4
        zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((sts_all[b] & $past(sts_all[b] & ~clr)) == $past(sts_all[b] & ~clr)));
    end

    // R8
    grp2_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_grp[2] == (|sts_all[1][21:14]));

    // R9
    any_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any == ((|sts_all[0]) || (|sts_all[1])));

    // R10
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_all[1][31:22] == '0) && (en_all[1][31:22] == '0));

endmodule

bind gpio_edge_irq gpio_edge_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .sts_all   (sts_all),
    .en_all    (en_all),
    .irq_grp   (irq_grp),
    .irq_any   (irq_any)
);

// File: tb/test_gpio_edge_irq.sv
module test_gpio_edge_irq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [53:0] gpio_in = '0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq_grp;
    logic        irq_any;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string       req;
        int          kind;   // 0: bus_rdata, 1: {irq_any, irq_grp}
        logic [31:0] exp;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    gpio_edge_irq i_gpio_edge_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .gpio_in   (gpio_in),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_grp   (irq_grp),
        .irq_any   (irq_any)
    );

    // Monitor: pops expected items and compares them with the outputs.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = (it.kind == 0) ? bus_rdata : {28'd0, irq_any, irq_grp};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            finish_run();
        end
    end

    task automatic chk_rd(string req, logic [3:0] addr, logic [31:0] exp);
        bus_addr = addr;
        sb_q.push_back('{req, 0, exp});
        @(negedge clk);
    endtask

    task automatic chk_irq(string req, logic [3:0] exp);
        sb_q.push_back('{req, 1, {28'd0, exp}});
        @(negedge clk);
    endtask

    task automatic bus_write(logic [3:0] addr, logic [31:0] data);
        bus_addr  = addr;
        bus_wdata = data;
        bus_wen   = 1'b1;
        @(negedge clk);
        bus_wen   = 1'b0;
    endtask

    // Drive a pin level and wait until a resulting pending bit is due.
    task automatic set_pin(int idx, logic v);
        gpio_in[idx] = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R11 reset state
        chk_rd("R1 sts0", 4'h0, 32'h0);
        chk_rd("R1 sts1", 4'h4, 32'h0);
        chk_rd("R1 en0",  4'h8, 32'h0);
        chk_rd("R1 en1",  4'hC, 32'h0);
        chk_irq("R1 irq", 4'b0000);

        bus_write(4'h8, 32'hFFFF_FFFF);
        bus_write(4'hC, 32'hFFFF_FFFF);
        chk_rd("R11 en0", 4'h8, 32'hFFFF_FFFF);
        chk_rd("R10 en1", 4'hC, 32'h003F_FFFF);

        // R2 / R6 / R9 / R12: pin 5
        set_pin(5, 1'b1);
        chk_rd("R2 sts0", 4'h0, 32'h0000_0020);
        chk_irq("R6 R9 grp0", 4'b1001);
        bus_write(4'h0, 32'h0);
        chk_rd("R4 zero write", 4'h0, 32'h0000_0020);
        bus_write(4'h0, 32'h0000_0020);
        chk_rd("R4 clear", 4'h0, 32'h0);
        chk_irq("R12 irq drop", 4'b0000);

        // R7: group spanning banks
        set_pin(30, 1'b1);
        chk_irq("R7 bank0 part", 4'b1010);
        set_pin(33, 1'b1);
        chk_rd("R11 sts1", 4'h4, 32'h0000_0002);
        bus_write(4'h0, 32'h4000_0000);
        chk_irq("R7 bank1 part", 4'b1010);
        bus_write(4'h4, 32'h0000_0002);
        chk_irq("R7 cleared", 4'b0000);

        // R8
        set_pin(50, 1'b1);
        chk_rd("R8 sts1", 4'h4, 32'h0004_0000);
        chk_irq("R8 grp2", 4'b1100);
        bus_write(4'h4, 32'hFFFF_FFFF);
        chk_rd("R10 sts1 after ones", 4'h4, 32'h0);

        // R11 misaligned access
        bus_write(4'h9, 32'h0);
        chk_rd("R11 misaligned read", 4'h1, 32'h0);
        chk_rd("R11 misaligned write ignored", 4'h8, 32'hFFFF_FFFF);

        // R3: falling edge, then disabled bank
        set_pin(5, 1'b0);
        chk_rd("R3 falling", 4'h0, 32'h0);
        bus_write(4'h8, 32'h0);
        set_pin(7, 1'b1);
        chk_rd("R3 disabled", 4'h0, 32'h0);
        chk_irq("R3 irq", 4'b0000);
        bus_write(4'h8, 32'hFFFF_FFFF);
        repeat (2) @(negedge clk);
        chk_rd("R3 no late latch", 4'h0, 32'h0);

        // R5: edge and clear meet at the same clock edge
        set_pin(9, 1'b1);
        chk_rd("R5 setup", 4'h0, 32'h0000_0200);
        set_pin(9, 1'b0);
        @(negedge clk);
        gpio_in[9] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_write(4'h0, 32'h0000_0200);
        chk_rd("R5 edge wins", 4'h0, 32'h0000_0200);
        bus_write(4'h0, 32'h0000_0200);
        chk_rd("R4 final clear", 4'h0, 32'h0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule